// File: doc/BRIEF.md
# Prescaled Timer Waveform Generator

This block is a 16-bit up/down timer with a power-of-two clock prescaler and two compare channels that drive two waveform outputs. Each channel produces either a pulse-width-modulated level (high while the count is below its compare value) or a square wave that toggles on every compare match. In the two "match" waveform modes, compare channel 0 becomes the counter's top value, which sets the period. In the two "normal" modes, the top value is full scale.

Software programs the block through a small write-only register port. Address 0 holds the control word, address 1 holds compare 0, address 2 holds compare 1, and address 3 is the status clear strobe. The `retrig` input, or a start bit in the control word, returns the counter to its start value. One of three reload policies decides when that reload happens and what becomes of the prescaler phase. A one-shot option stops the counter after its first wrap until the next trigger arrives. One-clock pulses report compare matches and wraps, and sticky status bits record them.

Top module: `wave_timer16`

## Requirements
- R1: Control bits [2:0] select the prescaler. Codes 0 to 7 give one count step every 1, 2, 4, 8, 16, 64, 256 or 1024 clocks while the enable bit (control bit 11) is set.
- R2: Control bit 3 selects the direction: 0 counts up, 1 counts down. While the enable bit is clear, the count sits at its start value (0 when counting up, top when counting down) and the prescaler is held at zero. After enabling, the first step lands one prescaler period after the enabling write's edge.
- R3: Control bits [5:4] select the waveform mode: 0 normal frequency, 1 match frequency, 2 normal PWM, 3 match PWM. In modes 0 and 2 the top value is 0xFFFF. In modes 1 and 3 the top value is compare 0 (address 1).
- R4: When counting up, a step from the top value goes to 0. When counting down, a step from 0 goes to the top value. Each such wrap gives a one-clock `ovfPulse` that appears together with the wrapped count.
- R5: A step taken while the count equals compare N gives a one-clock pulse on `matchPulse[N]`, which appears with the count that follows. Compare 1 is at address 2.
- R6: In PWM modes (2, 3), channel N is high exactly while the count is below compare N, before inversion.
- R7: In frequency modes (0, 1), channel N toggles on each of its match pulses. In mode 1 this gives a square wave of 2·(compare0+1) steps with 50% duty.
- R8: Control bits 9 and 10 invert channel 0 and channel 1 respectively, each on its own.
- R9: Reload policy 0 (control bits [7:6]) reloads the count to its start value on the clock edge of the trigger and leaves the prescaler phase unchanged. Policy 3 behaves the same way.
- R10: Reload policy 1 keeps the count unchanged until the next prescaler step. That step loads the start value instead of counting.
- R11: Reload policy 2 reloads the count on the trigger edge and clears the prescaler, so the next step comes one full prescaler period later.
- R12: With control bit 8 set (one-shot), the counter halts after its first wrap. It holds that value until `retrig` or a control write with bit 12 set (start) arrives. Either trigger restarts it from the start value.
- R13: Status bit 0 records wraps, bit 1 records matches on channel 0 and bit 2 records matches on channel 1. The bits stay set until a write of 1 to the same bit at address 3 clears them. A new event in the clearing cycle keeps its bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register address (0 control, 1 compare 0, 2 compare 1, 3 status clear) |
| wrData | input | 16 | Write data |
| retrig | input | 1 | Retrigger / start request |
| count | output | 16 | Current counter value |
| wave | output | 2 | Channel waveform outputs |
| matchPulse | output | 2 | One-clock compare match pulses |
| ovfPulse | output | 1 | One-clock wrap pulse |
| status | output | 3 | Sticky event flags |

## Verification
The embedded assertions watch the cycle-level invariants on every clock:
- an up step adds exactly one;
- the count does not move without a step or a reload;
- a wrap lands on the start value with its pulse;
- a resync trigger zeroes the prescaler;
- a halt only follows a one-shot wrap;
- sticky flags survive until cleared.

The properties cannot show periods, duty cycles and the placement of reloads. The bench shows them by sweeping:
- every prescaler code;
- a range of compare values in both PWM and frequency modes, with and without inversion;
- all three reload policies, triggered at a fixed point within the prescaler period.

// File: rtl/wave_timer_pkg.sv
package wave_timer_pkg;
  localparam int NUM_CH    = 2;
  localparam int MAX_SHIFT = 10;
  localparam int PRE_W     = MAX_SHIFT;
  localparam int STAT_W    = NUM_CH + 1;

  typedef enum logic [1:0] {
    WM_NORM_FREQ  = 2'd0,
    WM_MATCH_FREQ = 2'd1,
    WM_NORM_PWM   = 2'd2,
    WM_MATCH_PWM  = 2'd3
  } waveMode_e;

  typedef enum logic [1:0] {
    RL_CLOCK     = 2'd0,
    RL_TICK      = 2'd1,
    RL_RESYNC    = 2'd2,
    RL_CLOCK_ALT = 2'd3
  } reloadPol_e;

  typedef struct packed {
    logic              enable;
    logic [NUM_CH-1:0] invert;
    logic              oneShot;
    reloadPol_e        reloadPol;
    waveMode_e         waveMode;
    logic              countDown;
    logic [2:0]        prescCode;
  } tmrCfg_t;

  typedef struct packed {
    logic step;
    logic reload;
  } tmrStb_t;
endpackage

// File: rtl/wave_timer_ctrl.sv
module wave_timer_ctrl
  import wave_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         wrEn,
  input  logic [1:0]                   wrAddr,
  input  logic [CNT_W-1:0]             wrData,
  input  logic                         retrig,
  input  logic                         wrapEvt,
  output tmrCfg_t                      cfg,
  output logic [NUM_CH-1:0][CNT_W-1:0] cc,
  output logic [STAT_W-1:0]            clrMask,
  output tmrStb_t                      stb
);
  logic [PRE_W-1:0] preCnt;
  logic             halted;
  logic             pend;
  logic             tick;
  logic             trig;
  logic             startCmd;
  logic             unusedHi;

  assign unusedHi = ^wrData[CNT_W-1:13];

  function automatic logic [PRE_W-1:0] divLast(input logic [2:0] code);
    int sh;
    sh = (code <= 3'd4) ? int'(code) : 2 * int'(code) - 4;
    return PRE_W'((32'd1 << sh) - 32'd1);
  endfunction

  assign startCmd = wrEn && (wrAddr == 2'd0) && wrData[12];
  assign trig     = cfg.enable && (retrig || startCmd);
  assign tick     = cfg.enable && (preCnt >= divLast(cfg.prescCode));
  assign clrMask  = (wrEn && wrAddr == 2'd3) ? wrData[STAT_W-1:0] : '0;

  always_comb begin
    stb.reload = !cfg.enable
              || (trig && cfg.reloadPol != RL_TICK)
              || (pend && tick);
    stb.step   = tick && !halted && !stb.reload;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfg    <= '0;
      cc     <= '0;
      preCnt <= '0;
      halted <= 1'b0;
      pend   <= 1'b0;
    end else begin
      if (wrEn && wrAddr == 2'd0) begin
        cfg.prescCode <= wrData[2:0];
        cfg.countDown <= wrData[3];
        cfg.waveMode  <= waveMode_e'(wrData[5:4]);
        cfg.reloadPol <= reloadPol_e'(wrData[7:6]);
        cfg.oneShot   <= wrData[8];
        cfg.invert    <= wrData[10:9];
        cfg.enable    <= wrData[11];
      end
      if (wrEn && wrAddr == 2'd1) cc[0] <= wrData;
      if (wrEn && wrAddr == 2'd2) cc[1] <= wrData;
      if (!cfg.enable) begin
        preCnt <= '0;
        halted <= 1'b0;
        pend   <= 1'b0;
      end else begin
        if (trig && cfg.reloadPol == RL_RESYNC) preCnt <= '0;
        else if (tick)                          preCnt <= '0;
        else                                    preCnt <= preCnt + 1'b1;
        if (trig)                         halted <= 1'b0;
        else if (cfg.oneShot && wrapEvt)  halted <= 1'b1;
        if (trig && cfg.reloadPol == RL_TICK) pend <= 1'b1;
        else if (tick)                        pend <= 1'b0;
      end
    end
  end

  // R11: a resync trigger restarts the prescaler phase
  a_r11_presc_cleared: assert property (@(posedge clk) disable iff (!rstN)
    (trig && cfg.reloadPol == RL_RESYNC) |=> (preCnt == '0));

  // R12: the counter only stops after a one-shot wrap
  a_r12_halt_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(halted) |-> ($past(wrapEvt) && $past(cfg.oneShot)));
endmodule

// File: rtl/wave_timer_dpath.sv
module wave_timer_dpath
  import wave_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  tmrCfg_t                      cfg,
  input  logic [NUM_CH-1:0][CNT_W-1:0] cc,
  input  tmrStb_t                      stb,
  input  logic [STAT_W-1:0]            clrMask,
  output logic [CNT_W-1:0]             count,
  output logic [NUM_CH-1:0]            wave,
  output logic [NUM_CH-1:0]            matchPulse,
  output logic                         ovfPulse,
  output logic [STAT_W-1:0]            status,
  output logic                         wrapEvt
);
  logic [CNT_W-1:0]  topVal;
  logic [CNT_W-1:0]  startVal;
  logic              atEnd;
  logic              pwmMode;
  logic [NUM_CH-1:0] hit;
  logic              unusedCfg;

  assign unusedCfg = ^{cfg.prescCode, cfg.reloadPol, cfg.oneShot};
  assign pwmMode   = cfg.waveMode[1];
  assign topVal    = cfg.waveMode[0] ? cc[0] : '1;
  assign startVal  = cfg.countDown ? topVal : '0;
  assign atEnd     = cfg.countDown ? (count == '0) : (count >= topVal);
  assign wrapEvt   = stb.step && atEnd;

  generate
    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      logic tog;
      assign hit[i] = stb.step && (count == cc[i]);
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                    tog <= 1'b0;
        else if (!cfg.enable)         tog <= 1'b0;
        else if (hit[i] && !pwmMode)  tog <= ~tog;
      end
      assign wave[i] = (pwmMode ? (count < cc[i]) : tog) ^ cfg.invert[i];
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count      <= '0;
      matchPulse <= '0;
      ovfPulse   <= 1'b0;
      status     <= '0;
    end else begin
      if (stb.reload)     count <= startVal;
      else if (stb.step) begin
        if (atEnd)               count <= startVal;
        else if (cfg.countDown)  count <= count - 1'b1;
        else                     count <= count + 1'b1;
      end
      matchPulse <= hit;
      ovfPulse   <= wrapEvt;
      status     <= (status & ~clrMask) | {hit, wrapEvt};
    end
  end

  // R2: an up step away from the top adds exactly one
  a_r2_up_step: assert property (@(posedge clk) disable iff (!rstN)
    (stb.step && !cfg.countDown && !atEnd) |=> (count == CNT_W'($past(count) + 1'b1)));

  // R2: without a step or reload the count does not move
  a_r2_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.step && !stb.reload) |=> $stable(count));

  // R4: a wrap lands on the start value together with its pulse
  a_r4_wrap_start: assert property (@(posedge clk) disable iff (!rstN)
    wrapEvt |=> (ovfPulse && count == $past(startVal)));

  // R13: the wrap flag persists until it is cleared
  a_r13_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (status[0] && !clrMask[0]) |=> status[0]);
endmodule

// File: rtl/wave_timer16.sv
module wave_timer16
  import wave_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        wrAddr,
  input  logic [CNT_W-1:0]  wrData,
  input  logic              retrig,
  output logic [CNT_W-1:0]  count,
  output logic [NUM_CH-1:0] wave,
  output logic [NUM_CH-1:0] matchPulse,
  output logic              ovfPulse,
  output logic [STAT_W-1:0] status
);
  tmrCfg_t                      cfg;
  tmrStb_t                      stb;
  logic [NUM_CH-1:0][CNT_W-1:0] cc;
  logic [STAT_W-1:0]            clrMask;
  logic                         wrapEvt;

  wave_timer_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .retrig(retrig), .wrapEvt(wrapEvt), .cfg(cfg), .cc(cc),
    .clrMask(clrMask), .stb(stb)
  );

  wave_timer_dpath #(.CNT_W(CNT_W)) u_dpath (
    .clk(clk), .rstN(rstN), .cfg(cfg), .cc(cc), .stb(stb), .clrMask(clrMask),
    .count(count), .wave(wave), .matchPulse(matchPulse), .ovfPulse(ovfPulse),
    .status(status), .wrapEvt(wrapEvt)
  );
endmodule

// File: tb/wave_timer16_bench.sv
module wave_timer16_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrAddr = '0;
  logic [15:0] wrData = '0;
  logic        retrig = 1'b0;
  logic [15:0] count;
  logic [1:0]  wave;
  logic [1:0]  matchPulse;
  logic        ovfPulse;
  logic [2:0]  status;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wave_timer16 u_wave_timer16 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .retrig(retrig), .count(count), .wave(wave), .matchPulse(matchPulse),
    .ovfPulse(ovfPulse), .status(status)
  );

  function automatic logic [15:0] ctl(input int presc, input int down, input int mode,
                                      input int pol, input int os, input int inv,
                                      input int en, input int start);
    return 16'(presc | (down << 3) | (mode << 4) | (pol << 6) | (os << 8) |
               (inv << 9) | (en << 11) | (start << 12));
  endfunction

  function automatic int divOf(input int code);
    case (code)
      0: return 1;    1: return 2;   2: return 4;   3: return 8;
      4: return 16;   5: return 64;  6: return 256; default: return 1024;
    endcase
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic waitOvf(output int n, input int limit);
    n = 0;
    do begin @(negedge clk); n++; end while (!ovfPulse && n < limit);
  endtask

  task automatic pulseRetrig();
    @(negedge clk); retrig = 1'b1;
    @(negedge clk); retrig = 1'b0;
  endtask

  task automatic countHigh(input int len, output int h0, output int h1);
    h0 = 0; h1 = 0;
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      h0 += int'(wave[0]); h1 += int'(wave[1]);
    end
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    failures++;
    $display("FAIL watchdog: run did not complete");
    finishRun();
  end

  initial begin
    int n, h0, h1, pulses;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // Reset state (R2, R13)
    chk("R2 reset count", count, 0);
    chk("R13 reset status", status, 0);
    chk("R4 reset ovfPulse", ovfPulse, 0);
    chk("R7 reset wave", wave, 0);

    // R1: every prescaler code, match-frequency period of 4 steps
    wr(2'd1, 16'd3);
    for (int code = 0; code < 8; code++) begin
      wr(2'd0, 16'd0);
      wr(2'd0, ctl(code, 0, 1, 0, 0, 0, 1, 0));
      waitOvf(n, 10000);
      waitOvf(n, 10000);
      chk($sformatf("R1 period code %0d", code), n, 4 * divOf(code));
    end

    // R3/R4: normal frequency uses full-scale top
    wr(2'd0, 16'd0);
    wr(2'd0, ctl(0, 0, 0, 0, 0, 0, 1, 0));
    waitOvf(n, 70000);
    chk("R3 full-scale wrap edges", n, 65536);
    chk("R4 count after up wrap", count, 0);

    // R2/R4: down counting in match mode
    wr(2'd0, 16'd0);
    wr(2'd1, 16'd5);
    wr(2'd0, ctl(0, 1, 1, 0, 0, 0, 1, 0));
    waitOvf(n, 100);
    chk("R4 count after down wrap", count, 5);
    waitOvf(n, 100);
    chk("R2 down period", n, 6);
    @(negedge clk);
    chk("R4 one-clock pulse", ovfPulse, 0);
    chk("R2 down step", count, 4);

    // R6/R8: PWM sweep over compare 1, then inverted
    for (int inv = 0; inv < 2; inv++) begin
      for (int c = 0; c < 12; c++) begin
        wr(2'd0, 16'd0);
        wr(2'd1, 16'd9);
        wr(2'd2, 16'(c));
        wr(2'd0, ctl(0, 0, 3, 0, 0, inv * 2, 1, 0));
        repeat (3) @(negedge clk);
        countHigh(10, h0, h1);
        chk($sformatf("R6 ch1 highs cc1=%0d inv=%0d (R8)", c, inv), h1,
            inv ? 10 - (c < 10 ? c : 10) : (c < 10 ? c : 10));
        chk("R8 ch0 unaffected", h0, 9);
      end
    end

    // R7: frequency mode square waves
    for (int t = 1; t <= 6; t++) begin
      wr(2'd0, 16'd0);
      wr(2'd1, 16'(t));
      wr(2'd2, 16'd0);
      wr(2'd0, ctl(0, 0, 1, 0, 0, 0, 1, 0));
      repeat (2) @(negedge clk);
      countHigh(2 * (t + 1), h0, h1);
      chk($sformatf("R7 ch0 half period top=%0d", t), h0, t + 1);
      chk($sformatf("R7 ch1 half period top=%0d", t), h1, t + 1);
    end

    // R5: match pulse on channel 1
    wr(2'd0, 16'd0);
    wr(2'd1, 16'd7);
    wr(2'd2, 16'd2);
    wr(2'd0, ctl(0, 0, 1, 0, 0, 0, 1, 0));
    n = 0;
    do begin @(negedge clk); n++; end while (!matchPulse[1] && n < 100);
    chk("R5 count with match pulse", count, 3);
    n = 0;
    do begin @(negedge clk); n++; end while (!matchPulse[1] && n < 100);
    chk("R5 match spacing", n, 8);

    // R13: sticky flags and write-one clear
    wr(2'd0, 16'd0);
    chk("R13 all flags set", status, 7);
    wr(2'd3, 16'd1);
    chk("R13 clear wrap only", status, 6);
    wr(2'd3, 16'd6);
    chk("R13 clear matches", status, 0);

    // R12: one-shot, restart by retrig and by start bit
    wr(2'd1, 16'd4);
    wr(2'd0, ctl(0, 0, 1, 0, 1, 0, 1, 0));
    pulses = 0;
    for (int k = 0; k < 20; k++) begin @(negedge clk); pulses += int'(ovfPulse); end
    chk("R12 single wrap", pulses, 1);
    chk("R12 halted count", count, 0);
    pulseRetrig();
    pulses = 0;
    for (int k = 0; k < 20; k++) begin @(negedge clk); pulses += int'(ovfPulse); end
    chk("R12 wrap after retrig", pulses, 1);
    wr(2'd0, ctl(0, 0, 1, 0, 1, 0, 1, 1));
    pulses = 0;
    for (int k = 0; k < 20; k++) begin @(negedge clk); pulses += int'(ovfPulse); end
    chk("R12 wrap after start", pulses, 1);

    // R9/R10/R11: reload policies, prescale 8, trigger at edge 27
    for (int pol = 0; pol < 3; pol++) begin
      wr(2'd0, 16'd0);
      wr(2'd0, ctl(3, 0, 0, pol, 0, 0, 1, 0));
      repeat (26) @(negedge clk);
      chk($sformatf("R1 count before trigger pol=%0d", pol), count, 3);
      pulseRetrig();
      chk($sformatf("R%0s trigger edge", pol == 0 ? "9" : pol == 1 ? "10" : "11"), count,
          pol == 1 ? 3 : 0);
      repeat (5) @(negedge clk);
      if (pol == 0) chk("R9 edge 32", count, 1);
      if (pol == 1) chk("R10 edge 32", count, 0);
      if (pol == 2) chk("R11 edge 32", count, 0);
      repeat (3) @(negedge clk);
      if (pol == 0) chk("R9 edge 35", count, 1);
      if (pol == 1) chk("R10 edge 35", count, 0);
      if (pol == 2) chk("R11 edge 35", count, 1);
      repeat (5) @(negedge clk);
      if (pol == 0) chk("R9 edge 40", count, 2);
      if (pol == 1) chk("R10 edge 40", count, 1);
      if (pol == 2) chk("R11 edge 40", count, 1);
    end

    finishRun();
  end
endmodule